// File: doc/BRIEF.md
# Write-Once Configuration Register Block

This block is a small register file on a 32-bit register bus. It holds a main configuration register, a low-power control register, a read-only reset configuration register and a read-only identification register. Some bits of the main configuration register are write-once. Outside debug mode, the first write to such a bit takes effect and later writes to it are dropped. While debug mode is active, those bits can be written any number of times. A bit that was written during debug stays writable until the next reset.

Every access must have supervisor privilege. A user-mode access changes nothing and ends with a transfer error. The reset configuration register is captured while reset is asserted. If the override pin is high on the last reset cycle, it takes the boot pins. Otherwise it takes a fixed default.

A bus request is a single-cycle `req_valid` pulse. The response comes exactly one clock later on the `rsp_*` outputs.

Top module: `cfgreg_top`

## Requirements
- R1: Each cycle with `req_valid` high gives `rsp_valid` high on the next cycle. A cycle without a request gives `rsp_valid` low on the next cycle. Write responses and error responses carry zero read data.
- R2: A request with `req_super` low gives `rsp_err` high and zero read data. It changes no register and does not change `test_flag`.
- R3: The write-once bits are the bits set in `MAIN_WO_MASK` (default 16'h0F0F). Outside debug mode, a write covering a write-once bit that is not yet locked updates it and then locks it. Later writes to a locked bit leave it unchanged. Bits that are not write-once are always written.
- R4: While `dbg_mode` is high, every write to the main configuration register takes effect on all bits whose lane strobe is set.
- R5: A write-once bit written while `dbg_mode` is high never locks afterwards. It stays writable after debug ends, until reset.
- R6: Offset 0x04 holds the main register in bits 31:16 and the low-power register in bits 15:0. Byte lane k covers data bits 8k+7:8k, and only lanes with `req_strb[k]` set are written.
- R7: Offset 0x08 reads the reset configuration in bits 31:16 and `ID_VALUE` in bits 15:0. Writes to this offset are ignored and complete without error.
- R8: Offset 0x0C always reads zero. A supervisor write to it whose strobed bytes are nonzero sets `test_flag`, which stays set until reset.
- R9: On the last cycle of reset, the reset configuration loads {7'b0, 1'b1, boot_pins} if `ovr_pin` is high, and {7'b0, 1'b0, RCFG_DEFAULT} if it is low. It is held constant until the next reset. `boot_pins[7:5]`, `[4]` and `[3:0]` are data pins 26:24, 21 and 19:16.
- R10: After reset, main equals `MAIN_RST`, low-power equals `LP_RST`, `test_flag` is 0 and all write-once bits are unlocked.
- R11: Any other offset reads zero, ignores writes and responds without error for supervisor accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_mode | input | 1 | Debug mode active |
| ovr_pin | input | 1 | Reset configuration override |
| boot_pins | input | 8 | Data pins 26:24, 21, 19:16, sampled during reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | Supervisor privilege |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte lane strobes |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Transfer error |
| rsp_rdata | output | 32 | Read data |
| main_cfg | output | 16 | Main configuration value |
| lp_cfg | output | 16 | Low-power control value |
| rcfg_out | output | 16 | Reset configuration value |
| test_flag | output | 1 | Sticky reserved-write flag |

## Verification
The hardest situation to reach is a mix of lock states across the bits of one register. Some write-once bits are locked, some were touched in debug, and some are still fresh, all at the same time. Only a sequence of partial-lane writes with and without debug can build that state. The bench drives a sweep of all strobe patterns, first outside and then inside debug, with varying data. After each write it compares both registers to an arithmetic per-bit model of lock and debug history. It repeats reset with and without override to cover both capture paths.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int unsigned OFF_CFG  = 4;
  localparam int unsigned OFF_RCFG = 8;
  localparam int unsigned OFF_RSV  = 12;

  function automatic logic [31:0] lane_mask(input logic [3:0] strb);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{strb[k]}};
    return m;
  endfunction
endpackage

// File: rtl/cfgreg_wobits.sv
module cfgreg_wobits #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] WO_MASK = '0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dbg,
  input  logic [W-1:0] we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (WO_MASK[i]) begin : g_once
      logic locked, dbg_touched;
      always_ff @(posedge clk) begin
        if (rst) begin
          q[i]        <= RST_VAL[i];
          locked      <= 1'b0;
          dbg_touched <= 1'b0;
        end else if (we[i]) begin
          if (dbg || dbg_touched || !locked) q[i] <= wd[i];
          if (dbg) dbg_touched <= 1'b1;
          else if (!dbg_touched) locked <= 1'b1;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) q[i] <= RST_VAL[i];
        else if (we[i]) q[i] <= wd[i];
      end
    end
  end
endmodule

// File: rtl/cfgreg_rcfg.sv
module cfgreg_rcfg #(
  parameter int unsigned PIN_W = 8,
  parameter logic [PIN_W-1:0] DEFAULT = '0,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovr,
  input  logic [PIN_W-1:0] pins,
  output logic [OUT_W-1:0] cfg
);
  localparam int unsigned PAD_W = OUT_W - PIN_W - 1;
  always_ff @(posedge clk) begin
    if (rst) cfg <= ovr ? {{PAD_W{1'b0}}, 1'b1, pins} : {{PAD_W{1'b0}}, 1'b0, DEFAULT};
  end
endmodule

// File: rtl/cfgreg_top.sv
module cfgreg_top
  import cfgreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned PIN_W = 8,
  parameter logic [15:0] MAIN_WO_MASK = 16'h0F0F,
  parameter logic [15:0] MAIN_RST = 16'h0000,
  parameter logic [15:0] LP_RST = 16'h0000,
  parameter logic [15:0] ID_VALUE = 16'h2C51,
  parameter logic [7:0]  RCFG_DEFAULT = 8'h4C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_mode,
  input  logic              ovr_pin,
  input  logic [7:0]        boot_pins,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_super,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_strb,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [15:0]       main_cfg,
  output logic [15:0]       lp_cfg,
  output logic [15:0]       rcfg_out,
  output logic              test_flag
);
  localparam int unsigned WORD_W = 2 * HALF_W;

  logic sel_cfg, sel_rcfg, sel_rsv, wr_ok, rd_ok;
  logic [WORD_W-1:0] lanes, rd_word;

  assign sel_cfg  = (req_addr == ADDR_W'(OFF_CFG));
  assign sel_rcfg = (req_addr == ADDR_W'(OFF_RCFG));
  assign sel_rsv  = (req_addr == ADDR_W'(OFF_RSV));
  assign wr_ok    = req_valid && req_super && req_write;
  assign rd_ok    = req_valid && req_super && !req_write;
  assign lanes    = lane_mask(req_strb);

  cfgreg_wobits #(.W(HALF_W), .WO_MASK(MAIN_WO_MASK), .RST_VAL(MAIN_RST)) u_main (
    .clk(clk), .rst(rst), .dbg(dbg_mode),
    .we(lanes[WORD_W-1:HALF_W] & {HALF_W{wr_ok && sel_cfg}}),
    .wd(req_wdata[WORD_W-1:HALF_W]),
    .q(main_cfg)
  );

  cfgreg_wobits #(.W(HALF_W), .WO_MASK('0), .RST_VAL(LP_RST)) u_lp (
    .clk(clk), .rst(rst), .dbg(dbg_mode),
    .we(lanes[HALF_W-1:0] & {HALF_W{wr_ok && sel_cfg}}),
    .wd(req_wdata[HALF_W-1:0]),
    .q(lp_cfg)
  );

  cfgreg_rcfg #(.PIN_W(PIN_W), .DEFAULT(RCFG_DEFAULT), .OUT_W(HALF_W)) u_rcfg (
    .clk(clk), .rst(rst), .ovr(ovr_pin), .pins(boot_pins), .cfg(rcfg_out)
  );

  always_comb begin
    rd_word = '0;
    if (sel_cfg)       rd_word = {main_cfg, lp_cfg};
    else if (sel_rcfg) rd_word = {rcfg_out, ID_VALUE};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      test_flag <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !req_super;
      rsp_rdata <= rd_ok ? rd_word : '0;
      if (wr_ok && sel_rsv && |(req_wdata & lanes)) test_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgreg_chk.sv
module cfgreg_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [15:0] ID_VALUE = 16'h2C51
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_super,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic [15:0]       main_cfg,
  input logic [15:0]       lp_cfg,
  input logic [15:0]       rcfg_out,
  input logic              test_flag
);
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_user_err_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_super |=> rsp_err && rsp_rdata == 32'd0);
  p_user_nochg_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_super |=> $stable(main_cfg) && $stable(lp_cfg) && $stable(test_flag));
  p_super_noerr_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_super |=> !rsp_err);
  p_id_read_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_super && !req_write && req_addr == ADDR_W'(8) |=> rsp_rdata[15:0] == ID_VALUE);
  p_rsv_zero_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_addr == ADDR_W'(12) |=> rsp_rdata == 32'd0);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    test_flag |=> test_flag);
  p_rcfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(rcfg_out));
endmodule

bind cfgreg_top cfgreg_chk #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_super(req_super), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .main_cfg(main_cfg),
  .lp_cfg(lp_cfg), .rcfg_out(rcfg_out), .test_flag(test_flag)
);

// File: tb/cfgreg_top_test.sv
`timescale 1ns/1ps
module cfgreg_top_test;
  localparam logic [15:0] WO  = 16'h0F0F;
  localparam logic [15:0] ID  = 16'h2C51;
  localparam logic [7:0]  DEF = 8'h4C;

  logic clk = 0, rst = 1, dbg_mode = 0, ovr_pin = 0;
  logic [7:0] boot_pins = 0;
  logic req_valid = 0, req_write = 0, req_super = 1;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0] req_strb = 0;
  logic rsp_valid, rsp_err, test_flag;
  logic [31:0] rsp_rdata;
  logic [15:0] main_cfg, lp_cfg, rcfg_out;

  cfgreg_top #(.MAIN_WO_MASK(WO), .ID_VALUE(ID), .RCFG_DEFAULT(DEF)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic rv, re;
  logic [31:0] rd;
  logic [15:0] m_main, m_lp, m_lk, m_dt;
  logic m_flag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_main = 16'h0000; m_lp = 16'h0000; m_lk = 0; m_dt = 0; m_flag = 0;
  endtask

  task automatic do_reset(input bit ovr, input logic [7:0] pins);
    @(negedge clk);
    rst = 1; ovr_pin = ovr; boot_pins = pins;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] s, input bit sup, input bit dbg);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    req_strb = s; req_super = sup; dbg_mode = dbg;
    @(negedge clk);
    rv = rsp_valid; re = rsp_err; rd = rsp_rdata;
    req_valid = 0; dbg_mode = 0; req_super = 1;
  endtask

  task automatic model_wr(input logic [31:0] d, input logic [3:0] s, input bit dbg);
    for (int i = 0; i < 16; i++) begin
      if (s[2 + i/8]) begin
        if (!WO[i] || dbg || m_dt[i] || !m_lk[i]) m_main[i] = d[16+i];
        if (WO[i]) begin
          if (dbg) m_dt[i] = 1;
          else if (!m_dt[i]) m_lk[i] = 1;
        end
      end
      if (s[i/8]) m_lp[i] = d[i];
    end
  endtask

  task automatic chk_regs(input string tag);
    chk(main_cfg == m_main, {tag, " main"}, 32'(main_cfg), 32'(m_main));
    chk(lp_cfg == m_lp, {tag, " lp"}, 32'(lp_cfg), 32'(m_lp));
  endtask

  initial begin
    logic [31:0] d;
    // R10 and R9 with override
    do_reset(1, 8'hB6);
    @(negedge clk);
    chk(main_cfg == 16'h0 && lp_cfg == 16'h0, "R10 reset regs", {main_cfg, lp_cfg}, 0);
    chk(test_flag == 0, "R10 reset flag", 32'(test_flag), 0);
    chk(rcfg_out == 16'h01B6, "R9 override capture", 32'(rcfg_out), 32'h01B6);
    boot_pins = 8'h11; ovr_pin = 0;
    repeat (2) @(negedge clk);
    chk(rcfg_out == 16'h01B6, "R9 hold after reset", 32'(rcfg_out), 32'h01B6);
    xfer(0, 8'h08, 0, 4'hF, 1, 0);
    chk(rv && !re && rd == {16'h01B6, ID}, "R7 read rcfg/id", rd, {16'h01B6, ID});
    @(negedge clk);
    chk(rsp_valid == 0, "R1 idle no response", 32'(rsp_valid), 0);
    // R9 default path
    do_reset(0, 8'hFF);
    @(negedge clk);
    chk(rcfg_out == {8'h00, DEF}, "R9 default capture", 32'(rcfg_out), 32'({8'h00, DEF}));
    // R3 write-once
    xfer(1, 8'h04, 32'h1234_0000, 4'b1100, 1, 0); model_wr(32'h1234_0000, 4'b1100, 0);
    chk(rv && !re && rd == 0, "R1 write response", {rv, re, rd[29:0]}, 32'h8000_0000);
    chk(main_cfg == 16'h1234, "R3 first write", 32'(main_cfg), 32'h1234);
    xfer(1, 8'h04, 32'hABCD_0000, 4'b1100, 1, 0); model_wr(32'hABCD_0000, 4'b1100, 0);
    chk(main_cfg == 16'hA2C4, "R3 later write masked", 32'(main_cfg), 32'hA2C4);
    // R4 debug, R5 stays writable
    xfer(1, 8'h04, 32'h5555_0000, 4'b1100, 1, 1); model_wr(32'h5555_0000, 4'b1100, 1);
    chk(main_cfg == 16'h5555, "R4 debug write", 32'(main_cfg), 32'h5555);
    xfer(1, 8'h04, 32'h6666_0000, 4'b1100, 1, 1); model_wr(32'h6666_0000, 4'b1100, 1);
    chk(main_cfg == 16'h6666, "R4 debug rewrite", 32'(main_cfg), 32'h6666);
    xfer(1, 8'h04, 32'h9999_0000, 4'b1100, 1, 0); model_wr(32'h9999_0000, 4'b1100, 0);
    chk(main_cfg == 16'h9999, "R5 writable after debug", 32'(main_cfg), 32'h9999);
    // R6 lanes
    xfer(1, 8'h04, 32'h0000_BEEF, 4'b0001, 1, 0); model_wr(32'h0000_BEEF, 4'b0001, 0);
    chk(lp_cfg == 16'h00EF && main_cfg == 16'h9999, "R6 single lane", {main_cfg, lp_cfg}, 32'h9999_00EF);
    xfer(0, 8'h04, 0, 4'h0, 1, 0);
    chk(rd == {m_main, m_lp}, "R6 readback", rd, {m_main, m_lp});
    // R2 user mode
    xfer(1, 8'h04, 32'hFFFF_FFFF, 4'hF, 0, 0);
    chk(rv && re && rd == 0, "R2 user write error", {rv, re, rd[29:0]}, 32'hC000_0000);
    chk_regs("R2 user write no change");
    xfer(1, 8'h0C, 32'hFFFF_FFFF, 4'hF, 0, 0);
    chk(test_flag == 0, "R2 user reserved write", 32'(test_flag), 0);
    xfer(0, 8'h08, 0, 4'h0, 0, 0);
    chk(re && rd == 0, "R2 user read", {re, rd[30:0]}, 32'h8000_0000);
    // R7 write ignored
    xfer(1, 8'h08, 32'hFFFF_FFFF, 4'hF, 1, 0);
    chk(!re, "R7 write no error", 32'(re), 0);
    xfer(0, 8'h08, 0, 4'h0, 1, 0);
    chk(rd == {8'h00, DEF, ID}, "R7 write ignored", rd, {8'h00, DEF, ID});
    // R8 reserved
    xfer(1, 8'h0C, 32'h0000_0000, 4'hF, 1, 0);
    chk(test_flag == 0, "R8 zero write", 32'(test_flag), 0);
    xfer(1, 8'h0C, 32'h0000_FF00, 4'b0001, 1, 0);
    chk(test_flag == 0, "R8 unstrobed nonzero", 32'(test_flag), 0);
    xfer(1, 8'h0C, 32'h0000_0100, 4'b0010, 1, 0);
    chk(test_flag == 1, "R8 nonzero write", 32'(test_flag), 1);
    xfer(0, 8'h0C, 0, 4'h0, 1, 0);
    chk(rd == 0 && !re && test_flag, "R8 read zero sticky", rd, 0);
    chk_regs("R8 no side effect");
    // R11 other offsets
    xfer(1, 8'h00, 32'hFFFF_FFFF, 4'hF, 1, 0);
    xfer(0, 8'h00, 0, 4'h0, 1, 0);
    chk(rd == 0 && !re, "R11 offset 0", rd, 0);
    xfer(0, 8'h10, 0, 4'h0, 1, 0);
    chk(rd == 0 && !re, "R11 offset 0x10", rd, 0);
    chk_regs("R11 no side effect");
    // sweep: R3 R4 R5 R6
    do_reset(0, 8'h00);
    for (int k = 0; k < 64; k++) begin
      d = 32'(k) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
      xfer(1, 8'h04, d, 4'(k), 1, k[5]);
      model_wr(d, 4'(k), k[5]);
      chk_regs(k[5] ? "R4 R5 sweep" : "R3 R6 sweep");
    end
    xfer(0, 8'h04, 0, 4'h0, 1, 0);
    chk(rd == {m_main, m_lp}, "R6 sweep readback", rd, {m_main, m_lp});
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule